// File: doc/BRIEF.md
# Dual-Bank Flash Read Path Selector

This block sits on the read side of a two-bank NOR flash model. For every read it decides which source supplies the returned word: the array, the status register, the identification and protection codes, or the query table. The choice depends on the bank being addressed. One bank can report status or identification codes while the other bank keeps returning array contents.

The word address is split into a small bank of 8 Mbit and a large bank of 24 Mbit. The small bank holds eight 4 KWord parameter blocks and fifteen 32 KWord main blocks. The large bank holds forty-eight 32 KWord main blocks. A parameter places the parameter blocks at the top or at the bottom of the address space. The bank decode and the block numbering used for protection lookups both follow that parameter. The command decoder supplies mode flags, the owner of a running program or erase, a failure pulse and a read/reset pulse. The array and the status logic supply the raw data. The selected word is registered, so it appears one clock after the address is presented.

Top module: `flash_rd_path_sel`

## Requirements
- R1: Bank decode: with parameter blocks at the top, word addresses whose two upper bits (20:19) are both 1 form the small bank. With them at the bottom, addresses whose two upper bits are both 0 form it. Every other address is in the large bank. Bank id 0 is the small bank and id 1 is the large bank.
- R2: While `pe_active` is high, a read of the bank named by `pe_bank` returns the status byte on bits 7:0, zeros on bits 15:8, and `rd_src` = 1. A read of the other bank returns the array word with `rd_src` = 0, unless a mode flag applies to that bank.
- R3: An `op_fail` pulse seen while `pe_active` is high latches the owning bank as failed. An `op_fail` pulse while `pe_active` is low is ignored. Reads of the failed bank return status even after the operation ends. A `rd_reset` pulse clears the latch from the following cycle. A failure pulse in the same cycle as `rd_reset` wins.
- R4: Identification mode is per bank (`asel_en[id]`). A read of a bank in that mode returns identification data with `rd_src` = 2. A read of the other bank returns the array.
- R5: In identification mode, word address bits 1:0 = 00 return 0020h and 01 return the device code. The device code is 225Eh with parameter blocks at the top and 225Fh with them at the bottom. Bits 1:0 = 11 return 0000h.
- R6: In identification mode, bits 1:0 = 10 return 0001h if the addressed block's bit in `blk_prot` is set, and 0000h otherwise. Bottom placement numbers blocks 0-7 for the parameter blocks upward from address 0, then 8-70 for the main blocks. Top placement numbers main blocks 0-62 from address 0, then 63-70 for the parameter blocks.
- R7: `cfi_en` makes reads of either bank return `cfi_data` with `rd_src` = 3, taking priority over identification mode. Status reads of a busy or failed bank take priority over `cfi_en`.
- R8: In byte mode, `rd_data[15:8]` is zero and `hi_drive` is low. `rd_data[7:0]` carries the low byte of the selected word when `addr_lsb` is 0 and the high byte when it is 1. In word mode `hi_drive` is high and all 16 bits are returned.
- R9: Outputs are registered. The word selected from inputs present at a rising clock edge appears after that edge. Under synchronous reset `rd_data` = 0, `rd_src` = 0, `hi_drive` = 0, and the failure latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr | input | 21 | Word address of the read |
| addr_lsb | input | 1 | Byte lane select in byte mode |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| pe_active | input | 1 | A program or erase is running |
| pe_bank | input | 1 | Bank id that owns the running operation |
| op_fail | input | 1 | Pulse: the running operation failed |
| rd_reset | input | 1 | Pulse: read/reset command, clears a failure |
| asel_en | input | 2 | Per-bank identification mode, indexed by bank id |
| cfi_en | input | 1 | Query table mode, both banks |
| blk_prot | input | 71 | Protection bit per block number |
| arr_data | input | 16 | Array read word |
| stat_data | input | 8 | Status register byte |
| cfi_data | input | 16 | Query table word |
| rd_data | output | 16 | Registered read word |
| rd_src | output | 2 | Source of rd_data: 0 array, 1 status, 2 ident, 3 query |
| hi_drive | output | 1 | Upper data lane driven |

## Verification
On every cycle, the in-line assertions check several properties. A busy bank must read as status, and query mode must beat identification mode when no status applies. A bank with no mode must read as array. The bank decode must agree with the block numbering. Byte mode must leave the upper lane idle, and the failure latch must set, hold and clear as specified. Other behaviour needs directed scenarios and the bench's reference model. This covers the exact identification codes for each placement and the protection lookup against chosen protection patterns. It also covers the byte-lane contents and the persistence of status after a failed operation has ended.

// File: rtl/frps_pkg.sv
// Shared types of the read path selector.
// Assumes: bank id 0 = small (parameter) bank, 1 = large bank.
package frps_pkg;
    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_IDENT  = 2'd2,
        SRC_CFI    = 2'd3
    } rd_src_e;

    localparam logic BANK_SMALL = 1'b0;
    localparam logic BANK_LARGE = 1'b1;
endpackage

// File: rtl/frps_addr_decode.sv
// Address decode: bank id and block number of a word address.
// Assumes the small bank is the top or bottom quarter of the space,
// and that the outermost main-block slot is cut into parameter blocks.
module frps_addr_decode #(
    parameter int ADDR_W    = 21,
    parameter int MAIN_W    = 15,
    parameter int SUB_W     = 12,
    parameter bit PARAM_TOP = 1'b1,
    parameter int BLK_W     = 7
) (
    input  logic [ADDR_W-1:SUB_W] addr_hi,
    output logic                  bank_id,
    output logic [BLK_W-1:0]      blk_idx
);
    localparam int MIDX_W    = ADDR_W - MAIN_W;
    localparam int SIDX_W    = MAIN_W - SUB_W;
    localparam int NUM_PARAM = 1 << SIDX_W;
    localparam int NUM_MAIN  = (1 << MIDX_W) - 1;

    logic [MIDX_W-1:0] main_no;
    logic [SIDX_W-1:0] sub_no;

    assign main_no = addr_hi[ADDR_W-1:MAIN_W];
    assign sub_no  = addr_hi[MAIN_W-1:SUB_W];

    generate
        if (PARAM_TOP) begin : g_top
            // Small bank is the top quarter; last main slot holds parameter blocks.
            assign bank_id = ~(&addr_hi[ADDR_W-1:ADDR_W-2]);
            always_comb begin
                if (&main_no) blk_idx = BLK_W'(NUM_MAIN) + BLK_W'(sub_no);
                else          blk_idx = BLK_W'(main_no);
            end
        end else begin : g_bot
            // Small bank is the bottom quarter; first main slot holds parameter blocks.
            assign bank_id = |addr_hi[ADDR_W-1:ADDR_W-2];
            always_comb begin
                if (main_no == '0) blk_idx = BLK_W'(sub_no);
                else               blk_idx = BLK_W'(NUM_PARAM - 1) + BLK_W'(main_no);
            end
        end
    endgenerate
endmodule

// File: rtl/frps_fault_hold.sv
// Failure latch: remembers which bank saw a failed program or erase
// until a read/reset command. Assumes op_fail is only meaningful while
// pe_active is high; a failure in the same cycle as read/reset wins.
module frps_fault_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_active,
    input  logic pe_bank,
    input  logic op_fail,
    input  logic rd_reset,
    output logic err_valid,
    output logic err_bank
);
    logic fail_seen;
    assign fail_seen = op_fail & pe_active;

    // Set on a qualified failure, clear on read/reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_bank  <= 1'b0;
        end else if (fail_seen) begin
            err_valid <= 1'b1;
            err_bank  <= pe_bank;
        end else if (rd_reset) begin
            err_valid <= 1'b0;
        end
    end

    assert_fail_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fail && pe_active) |=> (err_valid && err_bank == $past(pe_bank)));
    assert_fail_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reset && !(op_fail && pe_active)) |=> !err_valid);
    assert_fail_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !rd_reset && !op_fail) |=> (err_valid && $stable(err_bank)));
endmodule

// File: rtl/frps_id_gen.sv
// Identification word generator: maker code, device code, block
// protection flag or zero, chosen by the two low word address bits.
module frps_id_gen #(
    parameter logic [15:0] MFR_CODE = 16'h0020,
    parameter logic [15:0] DEV_CODE = 16'h225E
) (
    input  logic [1:0]  sel,
    input  logic        prot_bit,
    output logic [15:0] id_word
);
    // Pick the identification word for the low address pair.
    always_comb begin
        unique case (sel)
            2'b00:   id_word = MFR_CODE;
            2'b01:   id_word = DEV_CODE;
            2'b10:   id_word = {15'd0, prot_bit};
            default: id_word = 16'h0000;
        endcase
    end
endmodule

// File: rtl/flash_rd_path_sel.sv
// Read path selector of a two-bank flash model. Chooses, per addressed
// bank, between status, query table, identification and array data,
// applies the byte lane and registers the result.
// Assumes only one bank owns a program or erase at a time.
module flash_rd_path_sel #(
    parameter int          ADDR_W     = 21,
    parameter int          MAIN_W     = 15,
    parameter int          SUB_W      = 12,
    parameter int          DATA_W     = 16,
    parameter int          STAT_W     = 8,
    parameter bit          PARAM_TOP  = 1'b1,
    parameter logic [15:0] MFR_CODE   = 16'h0020,
    parameter logic [15:0] DEV_TOP    = 16'h225E,
    parameter logic [15:0] DEV_BOTTOM = 16'h225F,
    localparam int NUM_BLOCKS = (1 << (MAIN_W - SUB_W)) + (1 << (ADDR_W - MAIN_W)) - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  addr_lsb,
    input  logic                  byte_mode,
    input  logic                  pe_active,
    input  logic                  pe_bank,
    input  logic                  op_fail,
    input  logic                  rd_reset,
    input  logic [1:0]            asel_en,
    input  logic                  cfi_en,
    input  logic [NUM_BLOCKS-1:0] blk_prot,
    input  logic [DATA_W-1:0]     arr_data,
    input  logic [STAT_W-1:0]     stat_data,
    input  logic [DATA_W-1:0]     cfi_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic [1:0]            rd_src,
    output logic                  hi_drive
);
    import frps_pkg::*;

    localparam int BLK_W     = $clog2(NUM_BLOCKS);
    localparam int LANE_W    = DATA_W / 2;
    localparam int NUM_SMALL = (1 << (MAIN_W - SUB_W)) + (1 << (ADDR_W - MAIN_W - 2)) - 1;
    localparam logic [15:0] DEV_CODE = PARAM_TOP ? DEV_TOP : DEV_BOTTOM;

    logic              bank_id;
    logic [BLK_W-1:0]  blk_idx;
    logic              err_valid;
    logic              err_bank;
    logic [15:0]       id_word;
    logic              status_hit;
    rd_src_e           src_n;
    logic [DATA_W-1:0] word_n;
    logic [DATA_W-1:0] data_n;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^rd_addr[SUB_W-1:2];

    frps_addr_decode #(
        .ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .SUB_W(SUB_W),
        .PARAM_TOP(PARAM_TOP), .BLK_W(BLK_W)
    ) u_decode (
        .addr_hi (rd_addr[ADDR_W-1:SUB_W]),
        .bank_id (bank_id),
        .blk_idx (blk_idx)
    );

    frps_fault_hold u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .pe_active (pe_active),
        .pe_bank   (pe_bank),
        .op_fail   (op_fail),
        .rd_reset  (rd_reset),
        .err_valid (err_valid),
        .err_bank  (err_bank)
    );

    frps_id_gen #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .sel      (rd_addr[1:0]),
        .prot_bit (blk_prot[blk_idx]),
        .id_word  (id_word)
    );

    // Status applies to the bank that is busy or holds a failure.
    assign status_hit = (pe_active && pe_bank == bank_id) ||
                        (err_valid && err_bank == bank_id);

    // Source priority: status, query table, identification, array.
    always_comb begin
        if (status_hit) begin
            src_n  = SRC_STATUS;
            word_n = DATA_W'(stat_data);
        end else if (cfi_en) begin
            src_n  = SRC_CFI;
            word_n = cfi_data;
        end else if (asel_en[bank_id]) begin
            src_n  = SRC_IDENT;
            word_n = DATA_W'(id_word);
        end else begin
            src_n  = SRC_ARRAY;
            word_n = arr_data;
        end
    end

    // Byte lane steering for the 8-bit bus.
    always_comb begin
        if (byte_mode)
            data_n = DATA_W'(addr_lsb ? word_n[DATA_W-1:LANE_W] : word_n[LANE_W-1:0]);
        else
            data_n = word_n;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_src   <= SRC_ARRAY;
            hi_drive <= 1'b0;
        end else begin
            rd_data  <= data_n;
            rd_src   <= src_n;
            hi_drive <= ~byte_mode;
        end
    end

    assert_bank_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_id == BANK_SMALL) == (PARAM_TOP ? (int'(blk_idx) >= NUM_BLOCKS - NUM_SMALL)
                                              : (int'(blk_idx) < NUM_SMALL)));
    assert_busy_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_active && pe_bank == bank_id) |=> (rd_src == SRC_STATUS));
    assert_idle_array_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_hit && !cfi_en && !asel_en[bank_id]) |=> (rd_src == SRC_ARRAY && rd_data == $past(data_n)));
    assert_cfi_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfi_en && !status_hit) |=> (rd_src == SRC_CFI));
    assert_byte_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |=> (!hi_drive && rd_data[DATA_W-1:LANE_W] == '0));
endmodule

// File: tb/tb_flash_rd_path_sel.sv
// Bench: two instances (parameter blocks at top and at bottom) driven with
// shared stimulus and compared every clock against a behavioural model.
module tb_flash_rd_path_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [20:0] rd_addr;
    logic        addr_lsb, byte_mode, pe_active, pe_bank, op_fail, rd_reset, cfi_en;
    logic [1:0]  asel_en;
    logic [70:0] blk_prot;
    logic [15:0] arr_data, cfi_data;
    logic [7:0]  stat_data;
    logic [15:0] rd_data_t, rd_data_b;
    logic [1:0]  rd_src_t, rd_src_b;
    logic        hi_t, hi_b;

    int vectors = 0;
    int fails = 0;
    bit m_err = 0;
    bit m_err_bank = 0;
    logic [15:0] ed_t, ed_b;
    logic [1:0]  es_t, es_b;
    logic        eh_t, eh_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rd_path_sel #(.PARAM_TOP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_lsb(addr_lsb),
        .byte_mode(byte_mode), .pe_active(pe_active), .pe_bank(pe_bank),
        .op_fail(op_fail), .rd_reset(rd_reset), .asel_en(asel_en), .cfi_en(cfi_en),
        .blk_prot(blk_prot), .arr_data(arr_data), .stat_data(stat_data),
        .cfi_data(cfi_data), .rd_data(rd_data_t), .rd_src(rd_src_t), .hi_drive(hi_t));

    flash_rd_path_sel #(.PARAM_TOP(1'b0)) dut_bot (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_lsb(addr_lsb),
        .byte_mode(byte_mode), .pe_active(pe_active), .pe_bank(pe_bank),
        .op_fail(op_fail), .rd_reset(rd_reset), .asel_en(asel_en), .cfi_en(cfi_en),
        .blk_prot(blk_prot), .arr_data(arr_data), .stat_data(stat_data),
        .cfi_data(cfi_data), .rd_data(rd_data_b), .rd_src(rd_src_b), .hi_drive(hi_b));

    // Behavioural model of one read, from the requirements.
    function automatic void model(input bit top, output logic [15:0] d,
                                  output logic [1:0] s, output logic h);
        int a, bank, blk, mainno, sub;
        logic [15:0] w;
        a = int'(rd_addr);
        mainno = a / 32768;
        sub = (a / 4096) % 8;
        if (top) begin
            bank = (a >= 3 * 524288) ? 0 : 1;
            blk  = (mainno == 63) ? 63 + sub : mainno;
        end else begin
            bank = (a < 524288) ? 0 : 1;
            blk  = (mainno == 0) ? sub : 7 + mainno;
        end
        if ((pe_active && int'(pe_bank) == bank) || (m_err && int'(m_err_bank) == bank)) begin
            s = 2'd1; w = {8'h00, stat_data};
        end else if (cfi_en) begin
            s = 2'd3; w = cfi_data;
        end else if (asel_en[bank]) begin
            s = 2'd2;
            case (a % 4)
                0: w = 16'h0020;
                1: w = top ? 16'h225E : 16'h225F;
                2: w = blk_prot[blk] ? 16'h0001 : 16'h0000;
                default: w = 16'h0000;
            endcase
        end else begin
            s = 2'd0; w = arr_data;
        end
        if (byte_mode) begin
            d = addr_lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
            h = 1'b0;
        end else begin
            d = w;
            h = 1'b1;
        end
    endfunction

    task automatic compare(input string tag);
        vectors += 2;
        if (rd_data_t !== ed_t || rd_src_t !== es_t || hi_t !== eh_t) begin
            fails++;
            $display("FAIL %s top: data %h exp %h, src %0d exp %0d, hi %0d exp %0d",
                     tag, rd_data_t, ed_t, rd_src_t, es_t, hi_t, eh_t);
        end
        if (rd_data_b !== ed_b || rd_src_b !== es_b || hi_b !== eh_b) begin
            fails++;
            $display("FAIL %s bottom: data %h exp %h, src %0d exp %0d, hi %0d exp %0d",
                     tag, rd_data_b, ed_b, rd_src_b, es_b, hi_b, eh_b);
        end
    endtask

    // One clock: predict from current inputs, step the model latch, check after the edge.
    task automatic step(input string tag);
        model(1'b1, ed_t, es_t, eh_t);
        model(1'b0, ed_b, es_b, eh_b);
        if (op_fail && pe_active) begin
            m_err = 1; m_err_bank = pe_bank;
        end else if (rd_reset) begin
            m_err = 0;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        addr_lsb = 0; byte_mode = 0; pe_active = 0; pe_bank = 0; op_fail = 0;
        rd_reset = 0; asel_en = 2'b00; cfi_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 0;
        rd_addr = '0;
        idle_inputs();
        blk_prot = '0;
        blk_prot[0] = 1; blk_prot[5] = 1; blk_prot[63] = 1; blk_prot[70] = 1; blk_prot[30] = 1;
        arr_data = 16'hA55A; stat_data = 8'h80; cfi_data = 16'h0051;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset values hold until the first edge after release.
        ed_t = 16'h0; es_t = 2'd0; eh_t = 1'b0;
        ed_b = 16'h0; es_b = 2'd0; eh_b = 1'b0;
        compare("R9 reset");

        // R1 / R9: array reads across the bank boundaries.
        rd_addr = 21'h000000; arr_data = 16'h1234; step("R1 array low");
        rd_addr = 21'h07FFFF; arr_data = 16'h4321; step("R1 array");
        rd_addr = 21'h180000; arr_data = 16'hBEEF; step("R1 array high");
        rd_addr = 21'h1FFFFF; arr_data = 16'hCAFE; step("R9 array top");

        // R2: program in bank 0 (small bank); each placement has its own small bank.
        pe_active = 1; pe_bank = 0; stat_data = 8'h4C;
        rd_addr = 21'h1F8123; step("R2 busy read");
        rd_addr = 21'h000040; step("R2 busy read");
        rd_addr = 21'h100000; step("R2 other bank");
        pe_bank = 1; rd_addr = 21'h100000; step("R2 large busy");

        // R3: failure latched on bank 1, survives end of operation, cleared by read/reset.
        op_fail = 1; step("R3 fail pulse");
        op_fail = 0; pe_active = 0; stat_data = 8'h20;
        rd_addr = 21'h100004; step("R3 hold status");
        rd_addr = 21'h1F8000; step("R3 other bank array");
        rd_reset = 1; step("R3 clear cycle");
        rd_reset = 0; rd_addr = 21'h100004; step("R3 cleared");
        op_fail = 1; step("R3 fail ignored when idle");
        op_fail = 0; step("R3 still array");
        pe_active = 1; pe_bank = 0; op_fail = 1; rd_reset = 1; step("R3 fail beats reset");
        op_fail = 0; rd_reset = 0; pe_active = 0; rd_addr = 21'h000010; step("R3 held after tie");
        rd_reset = 1; step("R3 clear");
        rd_reset = 0; step("R3 clear done");

        // R4 / R5: identification in the large bank only.
        asel_en = 2'b10;
        rd_addr = 21'h100000; step("R5 maker code");
        rd_addr = 21'h100001; step("R5 device code");
        rd_addr = 21'h100003; step("R5 reserved zero");
        rd_addr = 21'h1F8001; step("R4 other bank array");
        rd_addr = 21'h000001; step("R4 other bank array");
        // R6: protection lookups in both banks.
        asel_en = 2'b11;
        rd_addr = 21'h000002; step("R6 block 0");
        rd_addr = 21'h005002; step("R6 param sub 5");
        rd_addr = 21'h1F8002; step("R6 top first param");
        rd_addr = 21'h1FF002; step("R6 top last param");
        rd_addr = 21'h0F0002; step("R6 main block 30");
        rd_addr = 21'h0F8002; step("R6 main block 31");
        rd_addr = 21'h0E8002; step("R6 main block 29");

        // R7: query table over identification, status over query table.
        cfi_en = 1; cfi_data = 16'h0052;
        rd_addr = 21'h000000; step("R7 query small");
        rd_addr = 21'h100000; step("R7 query large");
        pe_active = 1; pe_bank = 1; step("R7 status over query");
        pe_active = 0; cfi_en = 0; asel_en = 2'b00;

        // R8: byte lanes for array and identification.
        byte_mode = 1; arr_data = 16'hC3A7;
        addr_lsb = 0; rd_addr = 21'h012345; step("R8 low lane");
        addr_lsb = 1; step("R8 high lane");
        asel_en = 2'b11; rd_addr = 21'h000001; step("R8 device code high lane");
        addr_lsb = 0; step("R8 device code low lane");
        byte_mode = 0; asel_en = 2'b00; step("R8 word mode");

        // Mixed stimulus: R2 R3 R4 R7 R8 against the model.
        for (int i = 0; i < 400; i++) begin
            rd_addr   = 21'($urandom);
            addr_lsb  = 1'($urandom);
            byte_mode = 1'($urandom);
            pe_active = ($urandom % 4) == 0;
            pe_bank   = 1'($urandom);
            op_fail   = ($urandom % 8) == 0;
            rd_reset  = ($urandom % 6) == 0;
            asel_en   = 2'($urandom);
            cfi_en    = ($urandom % 5) == 0;
            arr_data  = 16'($urandom);
            stat_data = 8'($urandom);
            cfi_data  = 16'($urandom);
            if (i % 50 == 0) blk_prot = {7'($urandom), 32'($urandom), 32'($urandom)};
            step("R2 R3 R4 R7 R8 mixed");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule